// File: doc/BRIEF.md
# Computer-Operating-Properly Watchdog with Reset-Vector-Overlaid Clear Register

This block watches an 8-bit microcontroller for runaway software. It counts cycles of a clock that runs at four times the bus rate. Software must write to the service address, 0xFFFF, before the count runs out. If it does not, the block issues a single-cycle reset request. The service address is shared with the low byte of the reset vector. A read of 0xFFFF therefore returns that vector byte, which arrives on an input, and a write to 0xFFFF with any data clears the count. The block never raises an interrupt.

Configuration inputs control three things: they switch the watchdog off, they pick one of two timeout lengths, and they can forbid the STOP instruction. A STOP executed while it is forbidden produces an illegal-opcode reset pulse. A small state machine follows the processor's power state:
- `ST_OFF` is entered from any state whenever the watchdog is switched off or monitor mode is active. It holds the counter at zero.
- `ST_OFF -> ST_RUN` when the watchdog is enabled again.
- `ST_RUN -> ST_WAIT` on wait mode. `ST_WAIT -> ST_RUN` when wait mode ends. The counter runs in both states.
- `ST_RUN` or `ST_WAIT -> ST_STOP` on stop mode. `ST_STOP -> ST_RUN` when stop mode ends. In `ST_STOP` counting is frozen and the prescaler (the low `LOW_W` bits of the count) is held at zero.

Top module: `cop_watchdog`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `cop_rst` and `illop_rst` are 0.
- R2: With `cfg_rate_fast`=0, `cop_rst` rises exactly 2^SLOW_W − 2^LOW_W clock cycles after the edge that accepted a service write. It is high for one cycle, and the next timeout follows after the same period.
- R3: With `cfg_rate_fast`=1, the period is 2^FAST_W − 2^LOW_W cycles.
- R4: A write (`bus_wr`=1) to address 0xFFFF with any data clears the count. A write to any other address has no effect on when the timeout occurs.
- R5: When `bus_rd`=1 and `bus_addr`=0xFFFF, `bus_rdata` equals `vec_lo`. In every other case it is 0x00.
- R6: While `cfg_cop_off`=1, `cop_rst` stays 0.
- R7: While `monitor_mode`=1, `cop_rst` stays 0 even if the watchdog is enabled.
- R8: While `wait_mode`=1, counting continues, and the timeout of R2 still occurs.
- R9: While `stop_mode`=1, `cop_rst` stays 0, counting is frozen and the prescaler bits are cleared. After stop mode ends, counting resumes one cycle later from the retained upper count bits, with zero low bits.
- R10: `stop_exec`=1 with `cfg_stop_blocked`=1 gives a one-cycle `illop_rst` pulse on the next edge. With `cfg_stop_blocked`=0 it gives none.
- R11: A service write in the cycle in which a timeout would be issued wins. No `cop_rst` follows, and a full new period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, four times the bus rate |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| vec_lo | input | 8 | Low byte of the reset vector |
| bus_rdata | output | 8 | Read data for the overlaid address |
| cfg_cop_off | input | 1 | Configuration: watchdog off |
| cfg_rate_fast | input | 1 | Configuration: short timeout |
| cfg_stop_blocked | input | 1 | Configuration: STOP instruction forbidden |
| monitor_mode | input | 1 | Monitor mode active |
| wait_mode | input | 1 | Processor in wait mode |
| stop_mode | input | 1 | Processor in stop mode |
| stop_exec | input | 1 | A STOP instruction is executing |
| cop_rst | output | 1 | Watchdog reset request pulse |
| illop_rst | output | 1 | Illegal-opcode reset request pulse |

## Verification
The bench builds the block with SLOW_W=8, FAST_W=6 and LOW_W=4. This gives periods of 240 and 48 cycles, so both rates, repeated timeouts and the clear-versus-timeout collision can be measured exactly, cycle by cycle. With a 16-cycle prescaler, a stop entered 21 cycles after a service write keeps one upper count step and loses five low counts. The bench then expects the timeout 225 cycles after stop mode ends, which makes the prescaler clearing visible at the reset output.

// File: rtl/cop_pkg.sv
package cop_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_WAIT = 2'd2,
        ST_STOP = 2'd3
    } cop_state_e;
endpackage

// File: rtl/cop_bus_decode.sv
module cop_bus_decode #(
    parameter int          AW       = 16,
    parameter int          DW       = 8,
    parameter logic [15:0] SVC_ADDR = 16'hFFFF
) (
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [DW-1:0] vec_byte,
    output logic          svc_hit,
    output logic [DW-1:0] rdata
);
    localparam logic [AW-1:0] MATCH = AW'(SVC_ADDR);

    logic addr_match;

    always_comb begin
        addr_match = (addr == MATCH);
        svc_hit    = wr && addr_match;
        rdata      = (rd && addr_match) ? vec_byte : '0;
    end
endmodule

// File: rtl/cop_fsm.sv
module cop_fsm
    import cop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cop_off,
    input  logic monitor,
    input  logic wait_mode,
    input  logic stop_mode,
    output logic cnt_en,
    output logic pre_clr,
    output logic off_clr
);
    cop_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (cop_off || monitor) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_RUN;
                ST_RUN:  state_d = stop_mode ? ST_STOP : (wait_mode ? ST_WAIT : ST_RUN);
                ST_WAIT: state_d = stop_mode ? ST_STOP : (wait_mode ? ST_WAIT : ST_RUN);
                ST_STOP: state_d = stop_mode ? ST_STOP : ST_RUN;
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        cnt_en  = 1'b0;
        pre_clr = 1'b0;
        off_clr = 1'b0;
        unique case (state_q)
            ST_OFF:  off_clr = 1'b1;
            ST_RUN:  cnt_en  = 1'b1;
            ST_WAIT: cnt_en  = 1'b1;
            ST_STOP: pre_clr = 1'b1;
            default: off_clr = 1'b1;
        endcase
    end
endmodule

// File: rtl/cop_counter.sv
module cop_counter #(
    parameter int SLOW_W = 18,
    parameter int FAST_W = 13,
    parameter int LOW_W  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_fast,
    input  logic cnt_en,
    input  logic pre_clr,
    input  logic off_clr,
    input  logic svc,
    output logic tmo
);
    localparam int CW = SLOW_W;
    localparam logic [CW-1:0] SLOW_LIM = CW'((64'd1 << SLOW_W) - (64'd1 << LOW_W) - 64'd1);
    localparam logic [CW-1:0] FAST_LIM = CW'((64'd1 << FAST_W) - (64'd1 << LOW_W) - 64'd1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic          at_lim;

    always_comb begin
        lim    = rate_fast ? FAST_LIM : SLOW_LIM;
        at_lim = (cnt_q >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (svc || off_clr) begin
            cnt_q <= '0;
        end else if (cnt_en) begin
            cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
        end else if (pre_clr) begin
            cnt_q[LOW_W-1:0] <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmo <= 1'b0;
        else        tmo <= cnt_en && at_lim && !svc && !off_clr;
    end
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog #(
    parameter int SLOW_W = 18,
    parameter int FAST_W = 13,
    parameter int LOW_W  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  vec_lo,
    output logic [7:0]  bus_rdata,
    input  logic        cfg_cop_off,
    input  logic        cfg_rate_fast,
    input  logic        cfg_stop_blocked,
    input  logic        monitor_mode,
    input  logic        wait_mode,
    input  logic        stop_mode,
    input  logic        stop_exec,
    output logic        cop_rst,
    output logic        illop_rst
);
    logic svc_hit, cnt_en, pre_clr, off_clr;

    cop_bus_decode #(.AW(16), .DW(8), .SVC_ADDR(16'hFFFF)) dec_i (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .vec_byte(vec_lo),
        .svc_hit(svc_hit), .rdata(bus_rdata)
    );

    cop_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .cop_off(cfg_cop_off), .monitor(monitor_mode),
        .wait_mode(wait_mode), .stop_mode(stop_mode),
        .cnt_en(cnt_en), .pre_clr(pre_clr), .off_clr(off_clr)
    );

    cop_counter #(.SLOW_W(SLOW_W), .FAST_W(FAST_W), .LOW_W(LOW_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .rate_fast(cfg_rate_fast), .cnt_en(cnt_en),
        .pre_clr(pre_clr), .off_clr(off_clr), .svc(svc_hit), .tmo(cop_rst)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) illop_rst <= 1'b0;
        else        illop_rst <= stop_exec && cfg_stop_blocked;
    end
endmodule

// File: rtl/cop_watchdog_chk.sv
module cop_watchdog_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  vec_lo,
    input logic [7:0]  bus_rdata,
    input logic        cfg_cop_off,
    input logic        monitor_mode,
    input logic        stop_mode,
    input logic        stop_exec,
    input logic        cfg_stop_blocked,
    input logic        cop_rst,
    input logic        illop_rst
);
    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cop_rst |=> !cop_rst);

    p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 16'hFFFF) |=> !cop_rst);

    p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cop_off && $past(cfg_cop_off) && $past(cfg_cop_off, 2)) |-> !cop_rst);

    p_monitor_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (monitor_mode && $past(monitor_mode) && $past(monitor_mode, 2)) |-> !cop_rst);

    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && $past(stop_mode) && $past(stop_mode, 2)) |-> !cop_rst);

    p_illop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_exec && cfg_stop_blocked) |=> illop_rst);

    p_no_illop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_exec && cfg_stop_blocked) |=> !illop_rst);

    p_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 16'hFFFF) |-> (bus_rdata == vec_lo));
endmodule

bind cop_watchdog cop_watchdog_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .vec_lo(vec_lo), .bus_rdata(bus_rdata), .cfg_cop_off(cfg_cop_off),
    .monitor_mode(monitor_mode), .stop_mode(stop_mode), .stop_exec(stop_exec),
    .cfg_stop_blocked(cfg_stop_blocked), .cop_rst(cop_rst), .illop_rst(illop_rst)
);

// File: tb/cop_watchdog_tb_top.sv
`timescale 1ns/1ps
module cop_watchdog_tb_top;
    localparam int SLOW_W = 8;
    localparam int FAST_W = 6;
    localparam int LOW_W  = 4;
    localparam int T_SLOW = (1 << SLOW_W) - (1 << LOW_W);
    localparam int T_FAST = (1 << FAST_W) - (1 << LOW_W);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  vec_lo = 8'h00;
    logic [7:0]  bus_rdata;
    logic        cfg_cop_off = 1'b0, cfg_rate_fast = 1'b0, cfg_stop_blocked = 1'b0;
    logic        monitor_mode = 1'b0, wait_mode = 1'b0, stop_mode = 1'b0, stop_exec = 1'b0;
    logic        cop_rst, illop_rst;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cop_watchdog #(.SLOW_W(SLOW_W), .FAST_W(FAST_W), .LOW_W(LOW_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .vec_lo(vec_lo), .bus_rdata(bus_rdata), .cfg_cop_off(cfg_cop_off),
        .cfg_rate_fast(cfg_rate_fast), .cfg_stop_blocked(cfg_stop_blocked),
        .monitor_mode(monitor_mode), .wait_mode(wait_mode), .stop_mode(stop_mode),
        .stop_exec(stop_exec), .cop_rst(cop_rst), .illop_rst(illop_rst)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [15:0] a);
        bus_addr = a;
        bus_wr   = 1'b1;
        tick();
        bus_wr   = 1'b0;
    endtask

    task automatic cycles_to_rst(input int limit, output int n);
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            tick();
            if (cop_rst) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic count_pulses(input int cyc, output int p);
        p = 0;
        for (int i = 0; i < cyc; i++) begin
            tick();
            if (cop_rst) p++;
        end
    endtask

    task automatic t_reset();
        check("R1 cop_rst in reset", cop_rst, 0);
        check("R1 illop_rst in reset", illop_rst, 0);
        rst_n = 1'b1;
        tick();
        check("R1 cop_rst after release", cop_rst, 0);
        check("R1 illop_rst after release", illop_rst, 0);
    endtask

    task automatic t_read();
        vec_lo = 8'hA5; bus_addr = 16'hFFFF; bus_rd = 1'b1; #1;
        check("R5 vector byte read", bus_rdata, 8'hA5);
        vec_lo = 8'h3C; #1;
        check("R5 vector byte follows input", bus_rdata, 8'h3C);
        bus_addr = 16'h00FF; #1;
        check("R5 other address", bus_rdata, 0);
        bus_addr = 16'hFFFF; bus_rd = 1'b0; #1;
        check("R5 no read strobe", bus_rdata, 0);
    endtask

    task automatic t_slow();
        int n;
        bus_write(16'hFFFF);
        cycles_to_rst(T_SLOW + 10, n);
        check("R2 slow period", n, T_SLOW);
        tick();
        check("R2 single-cycle pulse", cop_rst, 0);
        cycles_to_rst(T_SLOW + 10, n);
        check("R2 repeated period", n, T_SLOW - 1);
    endtask

    task automatic t_fast();
        int n;
        cfg_rate_fast = 1'b1;
        bus_write(16'hFFFF);
        cycles_to_rst(T_FAST + 10, n);
        check("R3 fast period", n, T_FAST);
        cycles_to_rst(T_FAST + 10, n);
        check("R3 fast repeat", n, T_FAST);
        cfg_rate_fast = 1'b0;
        bus_write(16'hFFFF);
    endtask

    task automatic t_wrong_addr();
        int n;
        bus_write(16'hFFFF);
        repeat (100) tick();
        bus_write(16'hFFFE);
        cycles_to_rst(T_SLOW, n);
        check("R4 other address ignored", n, T_SLOW - 101);
        bus_write(16'hFFFF);
        repeat (100) tick();
        bus_write(16'hFFFF);
        cycles_to_rst(T_SLOW + 10, n);
        check("R4 service restarts period", n, T_SLOW);
    endtask

    task automatic t_disable();
        int p;
        cfg_cop_off = 1'b1;
        count_pulses(2 * T_SLOW + 20, p);
        check("R6 no reset while off", p, 0);
        cfg_cop_off = 1'b0;
        tick();
        bus_write(16'hFFFF);
    endtask

    task automatic t_monitor();
        int p;
        monitor_mode = 1'b1;
        count_pulses(2 * T_SLOW + 20, p);
        check("R7 no reset in monitor mode", p, 0);
        monitor_mode = 1'b0;
        tick();
        bus_write(16'hFFFF);
    endtask

    task automatic t_wait();
        int n;
        wait_mode = 1'b1;
        bus_write(16'hFFFF);
        cycles_to_rst(T_SLOW + 10, n);
        check("R8 wait mode timeout", n, T_SLOW);
        wait_mode = 1'b0;
    endtask

    task automatic t_stop();
        int n, p;
        bus_write(16'hFFFF);
        repeat (20) tick();
        stop_mode = 1'b1;
        count_pulses(2 * T_SLOW + 20, p);
        check("R9 no reset in stop", p, 0);
        stop_mode = 1'b0;
        cycles_to_rst(T_SLOW + 10, n);
        check("R9 prescaler cleared in stop", n, T_SLOW - 15);
    endtask

    task automatic t_illop();
        cfg_stop_blocked = 1'b1;
        stop_exec = 1'b1;
        tick();
        stop_exec = 1'b0;
        check("R10 illegal-opcode pulse", illop_rst, 1);
        tick();
        check("R10 pulse ends", illop_rst, 0);
        cfg_stop_blocked = 1'b0;
        stop_exec = 1'b1;
        tick();
        stop_exec = 1'b0;
        check("R10 allowed STOP gives no pulse", illop_rst, 0);
    endtask

    task automatic t_clear_wins();
        int n, p;
        bus_write(16'hFFFF);
        count_pulses(T_SLOW - 1, p);
        check("R11 no early pulse", p, 0);
        bus_write(16'hFFFF);
        check("R11 clear beats timeout", cop_rst, 0);
        cycles_to_rst(T_SLOW + 10, n);
        check("R11 full new period", n, T_SLOW);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_read();
        t_slow();
        t_fast();
        t_wrong_addr();
        t_disable();
        t_monitor();
        t_wait();
        t_stop();
        t_illop();
        t_clear_wins();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule